// File: doc/BRIEF.md
# Segmented Coherent Waveform Averager

The block builds a point-by-point sum of a repeating waveform. A record is `cfg_len` samples long, and one accumulator word is kept for each sample position. A pass adds one record, taken one sample per clock, into those words. The pass starts either on a trigger or when a programmed gap expires. The clock period sets the time grid, so a record always covers a whole number of clocks.

A run is made of up to `NSEG` segments. Each segment consists of `cfg_passes` passes. Each segment has three settings of its own:
- how its first pass starts: on a trigger, or after a timed pause with no trigger;
- whether it begins again from zero or keeps adding onto the totals left by the previous segment;
- whether its totals are streamed out when it ends.

Streamed words leave on a valid/ready port. While the port is held off, the block waits: it starts no new pass until the dump has fully drained. Dividing the sums into a mean is left to the consumer.

Top module: `seg_avg`

## Requirements
- R1: While reset is held and right after it, `out_valid`, `out_last`, `busy`, `done` and `overrun` are all 0.
- R2: The first pass of segment 0 writes each sample into its word without adding the old contents. The same applies to the first pass of any segment whose `cfg_restart` bit is 1.
- R3: A pass adds the signed 8-bit input, sign-extended to 40 bits, into the word of its sample position. Position 0 is `din` in the cycle that starts the pass. Position k is `din` k cycles later.
- R4: A segment whose `cfg_restart` bit is 0 adds onto the totals left by the previous segment.
- R5: When `cfg_gap_mode[k]` is 1, the first pass of segment k starts without a trigger, `cfg_gap`+1 cycles after the segment is entered. All later passes of that segment, and every pass of a segment whose bit is 0, wait for `trig`.
- R6: When `cfg_dump[k]` is 1, the block sends `cfg_len` words after segment k ends, position 0 first, with `out_last` high on the final word only. When the bit is 0, nothing is sent.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value. No word is lost, and no pass starts until the last word has been accepted.
- R8: A `trig` seen in the middle of a pass is ignored and increments `overrun`, which saturates and is cleared by an accepted start. A `trig` seen while no run is active changes nothing.
- R9: After `cfg_nseg` segments have finished, `done` is 1 and `busy` is 0.
- R10: A `start` is rejected if any of these holds: `cfg_len` is 0 or above `DEPTH`, `cfg_passes` is 0, or `cfg_nseg` is 0 or above `NSEG`. A `start` while `busy` is 1 is also ignored.
- R11: A trigger in the cycle right after the last sample of a pass is accepted and summed correctly, even when `cfg_len` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run with the current configuration |
| cfg_len | input | LW | Samples per record, 1 to DEPTH |
| cfg_passes | input | 32 | Passes per segment |
| cfg_nseg | input | SCW | Number of segments in a run |
| cfg_gap_mode | input | NSEG | Per segment: 1 = first pass starts after the gap, 0 = on trigger |
| cfg_restart | input | NSEG | Per segment: 1 = restart from zero, 0 = keep adding |
| cfg_dump | input | NSEG | Per segment: 1 = stream the totals at segment end |
| cfg_gap | input | GAPW | Gap length in cycles |
| trig | input | 1 | Pass trigger |
| din | input | SW | Signed input sample |
| out_data | output | AW | Accumulated word |
| out_valid | output | 1 | `out_data` is valid |
| out_last | output | 1 | Final word of a dump |
| out_ready | input | 1 | Consumer accepts the word |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run completed |
| overrun | output | OVW | Triggers ignored during passes |

## Verification
The bench targets four corner cases.
- A one-sample record triggered again in the very next cycle. A design without forwarding would lose the previous pass's sum.
- A segment set to continue that follows a dump. Clearing there would drop earlier totals, and skipping a clear in a restart segment would leak them.
- A gap-started segment whose later passes must still wait for triggers. A design that ran them freely would add extra passes.
- Long stretches of `out_ready` low. A wrong design would drop or change words, or would resume summing before the dump drained.

// File: rtl/seg_avg.sv
module seg_avg #(
  parameter int SW = 8,
  parameter int AW = 40,
  parameter int DEPTH = 64,
  parameter int NSEG = 4,
  parameter int GAPW = 16,
  parameter int OVW = 16,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH),
  localparam int SIW = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int SCW = $clog2(NSEG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [LW-1:0]   cfg_len,
  input  logic [31:0]     cfg_passes,
  input  logic [SCW-1:0]  cfg_nseg,
  input  logic [NSEG-1:0] cfg_gap_mode,
  input  logic [NSEG-1:0] cfg_restart,
  input  logic [NSEG-1:0] cfg_dump,
  input  logic [GAPW-1:0] cfg_gap,
  input  logic            trig,
  input  logic [SW-1:0]   din,
  output logic [AW-1:0]   out_data,
  output logic            out_valid,
  output logic            out_last,
  input  logic            out_ready,
  output logic            busy,
  output logic            done,
  output logic [OVW-1:0]  overrun
);
  typedef enum logic [2:0] {S_IDLE, S_ARM, S_GAP, S_RUN, S_FLUSH, S_DUMP, S_DONE} st_t;

  st_t st;
  logic [IW-1:0]   addr;
  logic [31:0]     pcnt;
  logic [SIW-1:0]  seg;
  logic [GAPW-1:0] gcnt;
  logic [LW-1:0]   dptr;
  logic [AW-1:0]   mem [DEPTH];
  logic [AW-1:0]   rd_q;
  logic            p1_v, p1_first;
  logic [IW-1:0]   p1_addr;
  logic [SW-1:0]   p1_s;

  wire cfg_ok = cfg_len != '0 && cfg_len <= LW'(DEPTH) && cfg_passes != '0 &&
                cfg_nseg != '0 && cfg_nseg <= SCW'(NSEG);
  wire gap_hit = st == S_GAP && gcnt == cfg_gap;
  wire s0_v = (st == S_ARM && trig) || gap_hit || st == S_RUN;
  wire [IW-1:0] s0_addr = (st == S_RUN) ? addr : '0;
  wire s0_first = pcnt == '0 && (seg == '0 || cfg_restart[seg]);
  wire pass_end = s0_v && LW'(s0_addr) == cfg_len - LW'(1);
  wire seg_done = pcnt == cfg_passes - 32'd1;
  wire [SIW-1:0] seg_nx = seg + SIW'(1);
  wire more_seg = SCW'(seg) + SCW'(1) < cfg_nseg;
  wire dump_end = st == S_DUMP && out_valid && out_ready && out_last;
  wire adv = (pass_end && seg_done && !cfg_dump[seg]) || dump_end;
  wire [AW-1:0] p1_ext = {{(AW-SW){p1_s[SW-1]}}, p1_s};
  wire [AW-1:0] sum = (p1_first ? '0 : rd_q) + p1_ext;

  assign busy = st != S_IDLE && st != S_DONE;
  assign done = st == S_DONE;

  always_ff @(posedge clk) begin
    if (p1_v) mem[p1_addr] <= sum;
    rd_q <= (p1_v && p1_addr == s0_addr) ? sum : mem[s0_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_v <= 1'b0; p1_first <= 1'b0; p1_addr <= '0; p1_s <= '0;
    end else begin
      p1_v <= s0_v; p1_first <= s0_first; p1_addr <= s0_addr; p1_s <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; addr <= '0; pcnt <= '0; seg <= '0; gcnt <= '0; dptr <= '0;
      overrun <= '0; out_valid <= 1'b0; out_last <= 1'b0; out_data <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE:
          if (start && cfg_ok) begin
            st <= cfg_gap_mode[0] ? S_GAP : S_ARM;
            seg <= '0; pcnt <= '0; gcnt <= '0; overrun <= '0;
          end
        S_GAP: if (!gap_hit) gcnt <= gcnt + GAPW'(1);
        S_RUN: begin
          addr <= addr + IW'(1);
          if (trig && overrun != '1) overrun <= overrun + OVW'(1);
        end
        S_FLUSH: begin st <= S_DUMP; dptr <= '0; end
        S_DUMP:
          if (!out_valid || out_ready) begin
            if (dptr < cfg_len) begin
              out_valid <= 1'b1;
              out_data  <= mem[dptr[IW-1:0]];
              out_last  <= dptr == cfg_len - LW'(1);
              dptr      <= dptr + LW'(1);
            end else begin
              out_valid <= 1'b0;
              out_last  <= 1'b0;
            end
          end
        default: ;
      endcase
      if (s0_v && !pass_end && st != S_RUN) begin
        st <= S_RUN;
        addr <= IW'(1);
      end
      if (pass_end) begin
        if (!seg_done) begin
          pcnt <= pcnt + 32'd1;
          st <= S_ARM;
        end else if (cfg_dump[seg]) st <= S_FLUSH;
      end
      if (adv) begin
        pcnt <= '0;
        gcnt <= '0;
        if (more_seg) begin
          seg <= seg_nx;
          st <= cfg_gap_mode[seg_nx] ? S_GAP : S_ARM;
        end else st <= S_DONE;
      end
    end
  end
endmodule

// File: rtl/seg_avg_chk.sv
module seg_avg_chk #(
  parameter int AW = 40,
  parameter int LW = 7,
  parameter int OVW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [LW-1:0]  cfg_len,
  input logic           out_valid,
  input logic           out_ready,
  input logic           out_last,
  input logic [AW-1:0]  out_data,
  input logic           busy,
  input logic           done,
  input logic [OVW-1:0] overrun
);
  a_r7_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  a_r6_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  a_r6_output_only_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);
  a_r9_done_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r10_empty_record_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && cfg_len == '0 |=> !busy);
  a_r8_overrun_never_drops: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> overrun >= $past(overrun));
endmodule

bind seg_avg seg_avg_chk #(.AW(AW), .LW(LW), .OVW(OVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len),
  .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
  .out_data(out_data), .busy(busy), .done(done), .overrun(overrun)
);

// File: tb/seg_avg_bench.sv
module seg_avg_bench;
  localparam int DEPTH = 64, NSEG = 4, AW = 40, LW = 7, SCW = 3, GAPW = 16, OVW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, trig = 1'b0, out_ready = 1'b0;
  logic [LW-1:0] cfg_len = '0;
  logic [31:0] cfg_passes = '0;
  logic [SCW-1:0] cfg_nseg = '0;
  logic [NSEG-1:0] cfg_gap_mode = '0, cfg_restart = '0, cfg_dump = '0;
  logic [GAPW-1:0] cfg_gap = '0;
  logic [7:0] din = '0;
  logic [AW-1:0] out_data;
  logic out_valid, out_last, busy, done;
  logic [OVW-1:0] overrun;

  int checks = 0, errors = 0;
  longint acc [DEPTH];
  int exp_over = 0;
  logic [AW-1:0] qd[$];
  bit ql[$];
  bit stall_prev = 1'b0;
  logic [AW-1:0] stall_dat = '0;
  int stall_seen = 0, stall_bad = 0;

  seg_avg u_seg_avg (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len), .cfg_passes(cfg_passes),
    .cfg_nseg(cfg_nseg), .cfg_gap_mode(cfg_gap_mode), .cfg_restart(cfg_restart),
    .cfg_dump(cfg_dump), .cfg_gap(cfg_gap), .trig(trig), .din(din),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
    .out_ready(out_ready), .busy(busy), .done(done), .overrun(overrun)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    out_ready = ($urandom_range(2) != 0);
    #1;
    if (stall_prev && out_valid && out_data !== stall_dat) stall_bad++;
    stall_prev = out_valid && !out_ready;
    stall_dat = out_data;
    if (stall_prev) stall_seen++;
    if (out_valid && out_ready) begin
      qd.push_back(out_data);
      ql.push_back(out_last);
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sx(input logic [7:0] v);
    return longint'($signed(v));
  endfunction

  task automatic trig_pass(input int len, input bit first, input bit inject);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      trig = (i == 0) || (inject && i == 1);
      din = 8'($urandom);
      if (first) acc[i] = sx(din); else acc[i] += sx(din);
    end
    if (inject) exp_over++;
  endtask

  task automatic gap_pass(input int len, input int gap, input bit first, input logic [7:0] c);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (gap + len + 4) @(negedge clk);
    for (int i = 0; i < len; i++)
      if (first) acc[i] = sx(c); else acc[i] += sx(c);
  endtask

  task automatic drain(input int len, input string req);
    while (qd.size() < len) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      check(qd[i] == acc[i][AW-1:0], req, longint'($signed(qd[i])), acc[i]);
      check(ql[i] == (i == len - 1), "R6 last flag", longint'(ql[i]), longint'(i == len - 1));
    end
    qd.delete();
    ql.delete();
  endtask

  task automatic run(input int len, input int passes, input int nseg, input logic [3:0] gm,
                     input logic [3:0] rs, input logic [3:0] dm, input int gap, input int bb,
                     input int inj_seg, input string req);
    logic [7:0] c;
    cfg_len = LW'(len); cfg_passes = passes; cfg_nseg = SCW'(nseg);
    cfg_gap_mode = gm; cfg_restart = rs; cfg_dump = dm; cfg_gap = GAPW'(gap);
    exp_over = 0;
    c = 8'($urandom);
    din = c;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < nseg; k++) begin
      for (int p = 0; p < passes; p++) begin
        bit first;
        first = (p == 0) && (k == 0 || rs[k]);
        if (p == 0 && gm[k]) gap_pass(len, gap, first, c);
        else begin
          if (p > 0) repeat ((bb < 0) ? $urandom_range(2) : bb) @(negedge clk) trig = 1'b0;
          trig_pass(len, first, (k == inj_seg) && (p == passes - 1) && len >= 2);
        end
      end
      c = 8'($urandom);
      @(negedge clk);
      trig = 1'b0;
      din = c;
      if (dm[k]) drain(len, req);
    end
    repeat (4) @(negedge clk);
    check(done == 1'b1, "R9 done", longint'(done), 1);
    check(busy == 1'b0, "R9 busy", longint'(busy), 0);
    check(overrun == OVW'(exp_over), "R8 overrun", longint'(overrun), exp_over);
    check(qd.size() == 0, "R6 no dump when bit clear", qd.size(), 0);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(out_valid == 0 && out_last == 0 && busy == 0 && done == 0 && overrun == 0,
          "R1 during reset", longint'({out_valid, out_last, busy, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 0 && busy == 0 && done == 0 && overrun == 0,
          "R1 after reset", longint'({out_valid, busy, done}), 0);

    for (int i = 0; i < 5; i++) begin
      @(negedge clk); trig = 1'b1; din = 8'($urandom);
    end
    @(negedge clk); trig = 1'b0;
    repeat (3) @(negedge clk);
    check(overrun == 0 && busy == 0 && qd.size() == 0, "R8 idle trigger ignored",
          longint'(overrun), 0);

    cfg_len = '0; cfg_passes = 2; cfg_nseg = 1;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    check(busy == 0, "R10 zero length", longint'(busy), 0);
    cfg_len = LW'(DEPTH + 1);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    check(busy == 0, "R10 length over depth", longint'(busy), 0);
    cfg_len = 4; cfg_nseg = 0;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    check(busy == 0, "R10 zero segments", longint'(busy), 0);
    cfg_nseg = 1; cfg_passes = 0;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    check(busy == 0, "R10 zero passes", longint'(busy), 0);

    // R2 R3 R4 R5 R6 R7: restart, continue, gap start, dumps under backpressure
    run(4, 3, 3, 4'b0010, 4'b0100, 4'b0111, 5, 0, 0, "R2 R3 R4 R5 dump words");
    // R11: one-sample record, triggers back to back
    run(1, 4, 2, 4'b0000, 4'b0000, 4'b0011, 0, 0, -1, "R11 back-to-back sum");
    // R5: gap of zero, continue across segments without intermediate dump
    run(6, 2, 3, 4'b0110, 4'b0000, 4'b0100, 0, 1, 1, "R4 R5 continued totals");
    // full depth record
    run(DEPTH, 2, 1, 4'b0000, 4'b0000, 4'b0001, 0, 0, 0, "R3 full depth");

    for (int n = 0; n < 6; n++) begin
      int ns;
      ns = 1 + $urandom_range(3);
      run(1 + $urandom_range(15), 1 + $urandom_range(3), ns, 4'($urandom), 4'($urandom),
          4'($urandom) | 4'(1 << (ns - 1)), $urandom_range(6), -1, $urandom_range(ns - 1),
          "R3 R4 random run");
    end

    check(stall_seen > 0, "R7 stalls exercised", stall_seen, 1);
    check(stall_bad == 0, "R7 data held while stalled", stall_bad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule